// File: doc/BRIEF.md
# Three-phase dual-rail full adder

This block is a cycle-level, synthesizable model of a one-bit full adder built in a pre-charged dual-rail style that uses three phases. Every internal logical signal travels on a pair of rails, a true rail and a false rail. Each operation first raises both rails of every pair (charge). Next, exactly one rail of each pair falls according to the data (evaluate). Finally, the remaining rail is pulled down as well (discharge). Because of this, every rail falls exactly once per operation whatever the operands are. The information sits in the timing of the fall, not in which rail moves.

The operands `a_i`, `b_i` and `cin_i` are single-rail. They are captured on a start strobe and encoded into rail pairs inside the block. The adder network uses only two kinds of dual-rail gates: an exclusive-OR gate, and an AND-type gate whose output rails are swapped to make NAND. Stages are joined through a configurable number of static inverter pairs. The sum and carry are registered at the end of the evaluate phase, and a one-cycle done pulse marks them. Two sticky flags report problems. One covers an illegal rail pair for the current phase. The other is raised by a per-rail toggle monitor when any rail does not fall exactly once in an operation.

Top module: `tdr_full_adder`

## Requirements
- R1: A start strobe sampled high while idle begins an operation: charge, evaluate and discharge follow for one clock cycle each, then idle. `done_o` is high for exactly the discharge cycle, i.e. the cycle after the third rising edge counted from the sampling edge.
- R2: During the charge phase, both rails of every internal pair are high.
- R3: During the evaluate phase, every pair is complementary, so exactly half of all rails fall in that cycle.
- R4: During the discharge phase and while idle, both rails of every pair are low, and in the discharge cycle the other half of the rails fall.
- R5: With `done_o` high, `sum_o` equals a XOR b XOR cin and `cout_o` equals the majority of the three operands captured at the strobe.
- R6: `sum_o` and `cout_o` change only on the edge that raises `done_o`, and they hold their value until the next result.
- R7: A strobe sampled during the discharge cycle starts the next charge phase at once. A strobe sampled during charge or evaluate is ignored: it adds no operation and does not alter the operands in flight.
- R8: `rail_err_o` goes high and stays high until reset if any pair is outside its legal state for the phase: 1/1 in charge, complementary in evaluate, 0/0 otherwise.
- R9: The toggle monitor counts falling edges per rail over each operation. `bal_err_o` goes high and stays high until reset if any rail's count at the end of discharge is not exactly one. No rail falls while idle or in charge.
- R10: After reset, `sum_o`, `cout_o`, `done_o`, `rail_err_o` and `bal_err_o` are all 0 and the block is idle.
- R11: The results, the timing and both flags are the same for any value of `INV_PAIRS`, the number of static inverter pairs between stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one phase per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Strobe that starts an operation and captures the operands |
| a_i | input | 1 | Operand a, single-rail |
| b_i | input | 1 | Operand b, single-rail |
| cin_i | input | 1 | Carry in, single-rail |
| sum_o | output | 1 | Registered sum |
| cout_o | output | 1 | Registered carry out |
| done_o | output | 1 | High for one cycle when a new sum and carry appear |
| rail_err_o | output | 1 | Sticky flag for an illegal rail pair state |
| bal_err_o | output | 1 | Sticky flag for a rail whose fall count in an operation is not one |

## Verification
The bench builds the adder with `INV_PAIRS` = 2 and `CNT_W` = 2. Two inverter pairs make every stage link four inversions deep, so an inverter count that flips rail polarity or disturbs the fall count becomes visible. A two-bit counter lets the monitor tell zero, one and repeated falls apart. All 64 ordered pairs of consecutive operand values are run, mixing idle gaps with back-to-back operations. Strobes that land in the charge and evaluate cycles carry inverted operands, so if one were wrongly accepted it would show up in the results.

// File: rtl/tdr_pkg.sv
package tdr_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_CHARGE = 2'd1,
    PH_EVAL   = 2'd2,
    PH_DISCH  = 2'd3
  } phase_e;

  typedef enum logic {
    GK_AND = 1'b0,
    GK_XOR = 1'b1
  } gate_kind_e;

  typedef struct packed {
    logic t;
    logic f;
  } drail_t;

  localparam int unsigned OPS_W = 3;

  // rail exchange: logical NOT in dual-rail form
  function automatic drail_t dr_swap(drail_t x);
    drail_t r;
    r.t = x.f;
    r.f = x.t;
    return r;
  endfunction

  // AND-type pull-down network; swap rails around it for NAND/OR/NOR
  function automatic drail_t dr_and_core(drail_t x, drail_t y);
    drail_t r;
    r.t = x.t & y.t;
    r.f = x.f | y.f;
    return r;
  endfunction

  function automatic drail_t dr_xor_core(drail_t x, drail_t y);
    drail_t r;
    r.t = (x.t & y.f) | (x.f & y.t);
    r.f = (x.t & y.t) | (x.f & y.f);
    return r;
  endfunction

  // single-rail to dual-rail encoder driven by the phase
  function automatic drail_t dr_encode(phase_e ph, logic v);
    drail_t r;
    case (ph)
      PH_CHARGE: begin r.t = 1'b1; r.f = 1'b1; end
      PH_EVAL:   begin r.t = v;    r.f = ~v;   end
      default:   begin r.t = 1'b0; r.f = 1'b0; end
    endcase
    return r;
  endfunction

  // legal pair state for a phase
  function automatic logic pair_ok(phase_e ph, drail_t x);
    case (ph)
      PH_CHARGE: return x.t & x.f;
      PH_EVAL:   return x.t ^ x.f;
      default:   return ~(x.t | x.f);
    endcase
  endfunction

  // arithmetic reference: {carry, sum} of ops[0]+ops[1]+ops[2]
  function automatic logic [1:0] fa_ref(logic [OPS_W-1:0] ops);
    return 2'(ops[0]) + 2'(ops[1]) + 2'(ops[2]);
  endfunction

endpackage

// File: rtl/tdr_phase_seq.sv
module tdr_phase_seq
  import tdr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [OPS_W-1:0] ops_i,
  output phase_e           phase_o,
  output logic [OPS_W-1:0] ops_q_o,
  output logic             accept_o
);

  phase_e phase_q, phase_nx;

  assign accept_o = start_i && (phase_q == PH_IDLE || phase_q == PH_DISCH);

  always_comb begin
    case (phase_q)
      PH_IDLE:   phase_nx = accept_o ? PH_CHARGE : PH_IDLE;
      PH_CHARGE: phase_nx = PH_EVAL;
      PH_EVAL:   phase_nx = PH_DISCH;
      default:   phase_nx = accept_o ? PH_CHARGE : PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      ops_q_o <= '0;
    end else begin
      phase_q <= phase_nx;
      if (accept_o) ops_q_o <= ops_i;
    end
  end

  assign phase_o = phase_q;

  AST_CHARGE_THEN_EVAL: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q == PH_CHARGE |=> phase_q == PH_EVAL); // R1
  AST_EVAL_THEN_DISCH: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q == PH_EVAL |=> phase_q == PH_DISCH); // R1
  AST_BUSY_KEEPS_OPS: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_CHARGE || phase_q == PH_EVAL) |=> $stable(ops_q_o)); // R7
  AST_DISCH_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_DISCH && start_i) |=> phase_q == PH_CHARGE); // R7

endmodule

// File: rtl/tdr_gate.sv
module tdr_gate
  import tdr_pkg::*;
#(
  parameter gate_kind_e KIND     = GK_AND,
  parameter bit         OUT_SWAP = 1'b0
)(
  input  logic   clk,
  input  logic   rst_n,
  input  phase_e phase_i,
  input  drail_t a_i,
  input  drail_t b_i,
  output drail_t y_o
);

  drail_t core, core_sw;

  generate
    if (KIND == GK_AND) begin : g_and
      assign core = dr_and_core(a_i, b_i);
    end else begin : g_xor
      assign core = dr_xor_core(a_i, b_i);
    end
    if (OUT_SWAP) begin : g_swap
      assign core_sw = dr_swap(core);
    end else begin : g_pass
      assign core_sw = core;
    end
  endgenerate

  // pull-ups in charge, evaluation network in evaluate, pull-downs otherwise
  always_comb begin
    case (phase_i)
      PH_CHARGE: begin y_o.t = 1'b1; y_o.f = 1'b1; end
      PH_EVAL:   y_o = core_sw;
      default:   begin y_o.t = 1'b0; y_o.f = 1'b0; end
    endcase
  end

  AST_GATE_COMPLEMENTARY: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_i == PH_EVAL && (a_i.t ^ a_i.f) && (b_i.t ^ b_i.f)) |-> (y_o.t ^ y_o.f)); // R3

endmodule

// File: rtl/tdr_inv_chain.sv
module tdr_inv_chain
  import tdr_pkg::*;
#(
  parameter int unsigned PAIRS = 1
)(
  input  drail_t d_i,
  output drail_t q_o
);

  localparam int unsigned STAGES = 2 * PAIRS;

  logic [STAGES:0] t_n;
  logic [STAGES:0] f_n;

  assign t_n[0] = d_i.t;
  assign f_n[0] = d_i.f;

  for (genvar s = 0; s < STAGES; s++) begin : g_inv
    assign t_n[s+1] = ~t_n[s];
    assign f_n[s+1] = ~f_n[s];
  end

  assign q_o.t = t_n[STAGES];
  assign q_o.f = f_n[STAGES];

endmodule

// File: rtl/tdr_toggle_mon.sv
module tdr_toggle_mon
  import tdr_pkg::*;
#(
  parameter int unsigned N_WIRES = 24,
  parameter int unsigned CNT_W   = 2
)(
  input  logic               clk,
  input  logic               rst_n,
  input  phase_e             phase_i,
  input  logic [N_WIRES-1:0] rails_i,
  output logic [N_WIRES-1:0] fall_o,
  output logic               bal_err_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [N_WIRES-1:0] prev_q;
  logic [N_WIRES-1:0] miss;

  assign fall_o = prev_q & ~rails_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= rails_i;
  end

  for (genvar w = 0; w < N_WIRES; w++) begin : g_wire
    logic [CNT_W-1:0] cnt_q, cnt_nx;

    always_comb begin
      if (cnt_q == CNT_MAX) cnt_nx = cnt_q;
      else                  cnt_nx = cnt_q + CNT_W'(fall_o[w]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                         cnt_q <= '0;
      else if (phase_i == PH_CHARGE)                      cnt_q <= '0;
      else if (phase_i == PH_EVAL || phase_i == PH_DISCH) cnt_q <= cnt_nx;
    end

    assign miss[w] = (cnt_nx != CNT_ONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bal_err_o <= 1'b0;
    else        bal_err_o <= bal_err_o | ((phase_i == PH_DISCH) && (|miss));
  end

  AST_NO_FALL_WHEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_i == PH_IDLE || phase_i == PH_CHARGE) |-> fall_o == '0); // R9
  AST_EVAL_HALF_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    phase_i == PH_EVAL |-> $countones(fall_o) == N_WIRES / 2); // R3
  AST_DISCH_HALF_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    phase_i == PH_DISCH |-> $countones(fall_o) == N_WIRES / 2); // R4

endmodule

// File: rtl/tdr_full_adder.sv
module tdr_full_adder
  import tdr_pkg::*;
#(
  parameter int unsigned INV_PAIRS = 1,
  parameter int unsigned CNT_W     = 2
)(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic a_i,
  input  logic b_i,
  input  logic cin_i,
  output logic sum_o,
  output logic cout_o,
  output logic done_o,
  output logic rail_err_o,
  output logic bal_err_o
);

  // pair indices in the rail network
  localparam int unsigned P_A   = 0;
  localparam int unsigned P_B   = 1;
  localparam int unsigned P_C   = 2;
  localparam int unsigned P_X1  = 3;
  localparam int unsigned P_N1  = 4;
  localparam int unsigned P_X1B = 5;
  localparam int unsigned P_N1B = 6;
  localparam int unsigned P_CB  = 7;
  localparam int unsigned P_SUM = 8;
  localparam int unsigned P_N2  = 9;
  localparam int unsigned P_N2B = 10;
  localparam int unsigned P_CO  = 11;
  localparam int unsigned N_PAIRS = 12;
  localparam int unsigned N_RAILS = 2 * N_PAIRS;

  phase_e             phase;
  logic [OPS_W-1:0]   ops_q;
  logic               accept;
  drail_t             net [N_PAIRS];
  logic [N_PAIRS-1:0] rails_t, rails_f, pair_bad;
  logic [N_RAILS-1:0] rails_all, fall_evt;

  tdr_phase_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .ops_i    ({cin_i, b_i, a_i}),
    .phase_o  (phase),
    .ops_q_o  (ops_q),
    .accept_o (accept)
  );

  // operand encoders
  for (genvar i = 0; i < OPS_W; i++) begin : g_enc
    assign net[P_A + i] = dr_encode(phase, ops_q[i]);
  end

  // stage 1: a^b and nand(a,b)
  tdr_gate #(.KIND(GK_XOR), .OUT_SWAP(1'b0)) u_x1 (
    .clk(clk), .rst_n(rst_n), .phase_i(phase),
    .a_i(net[P_A]), .b_i(net[P_B]), .y_o(net[P_X1]));
  tdr_gate #(.KIND(GK_AND), .OUT_SWAP(1'b1)) u_n1 (
    .clk(clk), .rst_n(rst_n), .phase_i(phase),
    .a_i(net[P_A]), .b_i(net[P_B]), .y_o(net[P_N1]));

  // domino links into stage 2
  tdr_inv_chain #(.PAIRS(INV_PAIRS)) u_lk_x1 (.d_i(net[P_X1]), .q_o(net[P_X1B]));
  tdr_inv_chain #(.PAIRS(INV_PAIRS)) u_lk_n1 (.d_i(net[P_N1]), .q_o(net[P_N1B]));
  tdr_inv_chain #(.PAIRS(INV_PAIRS)) u_lk_c  (.d_i(net[P_C]),  .q_o(net[P_CB]));

  // stage 2: sum and nand(a^b, cin)
  tdr_gate #(.KIND(GK_XOR), .OUT_SWAP(1'b0)) u_sum (
    .clk(clk), .rst_n(rst_n), .phase_i(phase),
    .a_i(net[P_X1B]), .b_i(net[P_CB]), .y_o(net[P_SUM]));
  tdr_gate #(.KIND(GK_AND), .OUT_SWAP(1'b1)) u_n2 (
    .clk(clk), .rst_n(rst_n), .phase_i(phase),
    .a_i(net[P_X1B]), .b_i(net[P_CB]), .y_o(net[P_N2]));

  tdr_inv_chain #(.PAIRS(INV_PAIRS)) u_lk_n2 (.d_i(net[P_N2]), .q_o(net[P_N2B]));

  // stage 3: carry = nand(nand(a,b), nand(a^b,cin))
  tdr_gate #(.KIND(GK_AND), .OUT_SWAP(1'b1)) u_co (
    .clk(clk), .rst_n(rst_n), .phase_i(phase),
    .a_i(net[P_N1B]), .b_i(net[P_N2B]), .y_o(net[P_CO]));

  // flatten rails and judge each pair
  for (genvar i = 0; i < N_PAIRS; i++) begin : g_pair
    assign rails_t[i]       = net[i].t;
    assign rails_f[i]       = net[i].f;
    assign rails_all[2*i+1] = net[i].t;
    assign rails_all[2*i]   = net[i].f;
    assign pair_bad[i]      = ~pair_ok(phase, net[i]);
  end

  tdr_toggle_mon #(.N_WIRES(N_RAILS), .CNT_W(CNT_W)) u_mon (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase_i   (phase),
    .rails_i   (rails_all),
    .fall_o    (fall_evt),
    .bal_err_o (bal_err_o)
  );

  // result register, loaded at the end of evaluate
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_o      <= 1'b0;
      cout_o     <= 1'b0;
      done_o     <= 1'b0;
      rail_err_o <= 1'b0;
    end else begin
      done_o     <= (phase == PH_EVAL);
      rail_err_o <= rail_err_o | (|pair_bad);
      if (phase == PH_EVAL) begin
        sum_o  <= net[P_SUM].t;
        cout_o <= net[P_CO].t;
      end
    end
  end

  AST_CHARGE_ALL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_CHARGE |-> (&rails_t && &rails_f)); // R2
  AST_EVAL_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_EVAL |-> (rails_t ^ rails_f) == '1); // R3
  AST_DISCH_ALL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DISCH || phase == PH_IDLE) |-> (rails_t | rails_f) == '0); // R4
  AST_RESULT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> {cout_o, sum_o} == fa_ref(ops_q)); // R5
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable({cout_o, sum_o})); // R6
  AST_DONE_IN_DISCH: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> phase == PH_DISCH); // R1
  AST_ACCEPT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> phase == PH_CHARGE); // R7
  AST_RAIL_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rail_err_o) |-> rail_err_o); // R8

endmodule

// File: tb/tdr_full_adder_tb_top.sv
module tdr_full_adder_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic a = 1'b0, b = 1'b0, c = 1'b0;
  logic sum, cout, done, rail_err, bal_err;

  int n_chk  = 0;
  int n_fail = 0;
  int n_push = 0;
  int n_done = 0;
  logic [1:0] exp_q[$];

  always #2 clk = ~clk;

  // R11: built with two inverter pairs per stage link
  tdr_full_adder #(.INV_PAIRS(2), .CNT_W(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start),
    .a_i(a), .b_i(b), .cin_i(c),
    .sum_o(sum), .cout_o(cout), .done_o(done),
    .rail_err_o(rail_err), .bal_err_o(bal_err)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] add3(input logic [2:0] v);
    int s;
    s = 0;
    for (int k = 0; k < 3; k++) s += v[k];
    return s[1:0];
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && done) begin
      logic [1:0] e;
      n_done++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R7", "result without accepted strobe", 1, 0);
      end else begin
        e = exp_q.pop_front();
        check({cout, sum} == e, "R5", "cout/sum", int'({cout, sum}), int'(e));
        check(rail_err == 1'b0, "R2 R3 R4", "rail_err_o", int'(rail_err), 0);
        check(bal_err == 1'b0, "R9", "bal_err_o", int'(bal_err), 0);
      end
    end
  end

  // driver; v = {cin, b, a}; ign 1/2 = stray strobe in charge/evaluate
  task automatic op(input logic [2:0] v, input bit b2b, input int ign);
    logic [1:0] e;
    e = add3(v);
    start = 1'b1;
    {c, b, a} = v;
    exp_q.push_back(e);
    n_push++;
    @(negedge clk);                       // charge
    if (ign == 1) begin start = 1'b1; {c, b, a} = ~v; end
    else start = 1'b0;
    @(negedge clk);                       // evaluate
    check(done == 1'b0, "R1", "done before discharge", int'(done), 0);
    if (ign == 2) begin start = 1'b1; {c, b, a} = ~v; end
    else start = 1'b0;
    @(negedge clk);                       // discharge
    check(done == 1'b1, "R1", "done in discharge", int'(done), 1);
    start = 1'b0;
    if (!b2b) begin
      @(negedge clk);                     // idle
      check(done == 1'b0, "R1", "done one cycle only", int'(done), 0);
      check({cout, sum} == e, "R6", "result held", int'({cout, sum}), int'(e));
    end
  endtask

  task automatic finish_run();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R1 watchdog expired actual=%0d expected=%0d", n_done, n_push);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check(sum == 1'b0, "R10", "sum_o", int'(sum), 0);
    check(cout == 1'b0, "R10", "cout_o", int'(cout), 0);
    check(done == 1'b0, "R10", "done_o", int'(done), 0);
    check(rail_err == 1'b0, "R10", "rail_err_o", int'(rail_err), 0);
    check(bal_err == 1'b0, "R10", "bal_err_o", int'(bal_err), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // all 8x8 transitions between consecutive operand values
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        op(3'(i), (j % 2) == 1, j % 3);
        op(3'(j), (i % 2) == 0, 0);
      end
    end
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R7", "pending results", exp_q.size(), 0);
    check(n_done == n_push, "R7", "result count", n_done, n_push);
    check(rail_err == 1'b0, "R8", "rail_err_o at end", int'(rail_err), 0);
    check(bal_err == 1'b0, "R9", "bal_err_o at end", int'(bal_err), 0);
    finish_run();
  end

endmodule